// File: doc/BRIEF.md
# Two-Level DMA Interrupt Aggregator

This block gathers single-cycle event pulses from a set of DMA channels and from a group of common controller error sources. It keeps them in per-group status registers and reduces them to one level-sensitive interrupt for the CPU. Every group (each channel, plus the common group) has two masks. The status-enable mask decides whether an incoming event is recorded. The signal-enable mask decides whether a recorded event is forwarded toward the CPU. Software removes recorded events by writing a clear mask, and only the bits set in that mask are cleared.

A summary word has one bit per channel and one extra bit for the common group. Each bit shows that the group holds at least one recorded event that is also signal-enabled. The CPU interrupt is the OR of the summary bits, gated by a global enable input. The block has no state machine. Each group is one register bank with a single next-state rule: hold, clear on a write, or set on an event. The bank is replicated once per channel, and one more copy serves the common group.

Software writes through a simple port. Each write carries a kind, a group selector (common or channel), a channel index and a data word. Events on channels use fixed bit positions. For example, block done is bit 0, whole transfer done is bit 1, source and destination transaction complete are bits 3 and 4, and aborted is bit 31. Common events are also at fixed positions, for example slave decode error at bit 0 and undefined-register decode at bit 8. The aggregator treats every bit the same way.

Top module: `dma_irq_aggr`

## Requirements
- R1: After reset, every status bit, status-enable bit and signal-enable bit is 0, the summary word is 0 and `irq` is low.
- R2: An event pulse on bit b of a group sets status bit b only if status-enable bit b of that group is 1. Otherwise the status bit stays 0.
- R3: A status bit that is set but whose signal-enable bit is 0 stays recorded in the status output but does not contribute to the summary word.
- R4: Summary bit N (for N below NUM_CH) is 1 exactly when channel N has a bit that is set in both its status and its signal-enable registers. Summary bit NUM_CH does the same for the common group.
- R5: A write of kind 2 (clear) clears exactly the status bits that are 1 in the data word. All other status bits are unchanged, and the clear mask is not stored.
- R6: If an enabled event arrives in the same cycle as a clear of the same bit, the bit ends up set.
- R7: `irq` is high exactly when `glb_irq_en` is 1 and any summary bit is 1. It is a level, combinational from the registered state and the enable.
- R8: The common group uses the same register semantics as a channel. It is selected by `cfg_common`=1, and its width is CMN_W bits.
- R9: Write kinds: 0 loads the status-enable register, 1 loads the signal-enable register, 2 clears status, and 3 is ignored. A write affects only the selected group and leaves every other channel and the common group untouched.
- R10: An event pulse sampled at a clock edge is visible in the status output, the summary and `irq` immediately after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_evt | input | NUM_CH*CH_W | Event pulses, channel c at bits [c*CH_W +: CH_W] |
| cmn_evt | input | CMN_W | Common-group event pulses |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 status-enable, 1 signal-enable, 2 clear, 3 none |
| cfg_common | input | 1 | 1 selects the common group, 0 a channel |
| cfg_chan | input | CH_IDX_W | Channel index for channel writes |
| cfg_wdata | input | DATA_W | Write data or clear mask |
| glb_irq_en | input | 1 | Global CPU interrupt enable |
| ch_status | output | NUM_CH*CH_W | Recorded channel status, same layout as ch_evt |
| cmn_status | output | CMN_W | Recorded common status |
| summary | output | NUM_CH+1 | Per-channel pending bits plus the common bit at NUM_CH |
| irq | output | 1 | Level interrupt to the CPU |

## Verification
The hardest case to reach is an event and a clear of the same bit in the same clock cycle, since the two come from unrelated sources. The bench drives the event pulse and the clear write together on one falling edge, so both are sampled at the same rising edge. A second hard case is a bit that is recorded but not forwarded. It is reached by setting a status bit with the signal-enable mask at 0, and then confirming that the status output shows the bit while the summary and `irq` stay low until the mask is loaded.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
    typedef enum logic [1:0] {
        CFG_STAT_EN = 2'd0,
        CFG_SIG_EN  = 2'd1,
        CFG_CLEAR   = 2'd2,
        CFG_NONE    = 2'd3
    } cfg_kind_e;
endpackage

// File: rtl/irq_evt_bank.sv
module irq_evt_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         stat_en_we,
    input  logic         sig_en_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] status,
    output logic         pending
);
    logic [W-1:0] stat_en_q;
    logic [W-1:0] sig_en_q;
    logic [W-1:0] clr_mask;
    logic [W-1:0] status_d;

    always_comb begin
        clr_mask = clr_we ? wdata : '0;
        status_d = (status & ~clr_mask) | (evt & stat_en_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_en_q <= '0;
            sig_en_q  <= '0;
            status    <= '0;
        end else begin
            if (stat_en_we) stat_en_q <= wdata;
            if (sig_en_we)  sig_en_q  <= wdata;
            status <= status_d;
        end
    end

    assign pending = |(status & sig_en_q);

    // R2
    rise_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status) & ~$past(stat_en_q)) == '0));
    // R5
    fall_needs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~status & $past(status) & ~$past(clr_mask)) == '0));
    // R6
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(evt & stat_en_q) & ~status) == '0));
endmodule

// File: rtl/dma_irq_aggr.sv
module dma_irq_aggr
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int CH_W     = 32,
    parameter int CMN_W    = 21,
    parameter int DATA_W   = 32,
    parameter int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CH*CH_W-1:0] ch_evt,
    input  logic [CMN_W-1:0]       cmn_evt,
    input  logic                   cfg_we,
    input  logic [1:0]             cfg_kind,
    input  logic                   cfg_common,
    input  logic [CH_IDX_W-1:0]    cfg_chan,
    input  logic [DATA_W-1:0]      cfg_wdata,
    input  logic                   glb_irq_en,
    output logic [NUM_CH*CH_W-1:0] ch_status,
    output logic [CMN_W-1:0]       cmn_status,
    output logic [NUM_CH:0]        summary,
    output logic                   irq
);
    localparam int SUM_W = NUM_CH + 1;

    logic wr_stat, wr_sig, wr_clr;

    always_comb begin
        wr_stat = 1'b0;
        wr_sig  = 1'b0;
        wr_clr  = 1'b0;
        if (cfg_we) begin
            unique case (cfg_kind_e'(cfg_kind))
                CFG_STAT_EN: wr_stat = 1'b1;
                CFG_SIG_EN:  wr_sig  = 1'b1;
                CFG_CLEAR:   wr_clr  = 1'b1;
                CFG_NONE:    ;
            endcase
        end
    end

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            logic hit;
            assign hit = !cfg_common && (cfg_chan == CH_IDX_W'(c));
            irq_evt_bank #(.W(CH_W)) bank_i (
                .clk        (clk),
                .rst_n      (rst_n),
                .evt        (ch_evt[c*CH_W +: CH_W]),
                .stat_en_we (wr_stat && hit),
                .sig_en_we  (wr_sig && hit),
                .clr_we     (wr_clr && hit),
                .wdata      (cfg_wdata[CH_W-1:0]),
                .status     (ch_status[c*CH_W +: CH_W]),
                .pending    (summary[c])
            );
        end
    endgenerate

    irq_evt_bank #(.W(CMN_W)) cmn_bank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (cmn_evt),
        .stat_en_we (wr_stat && cfg_common),
        .sig_en_we  (wr_sig && cfg_common),
        .clr_we     (wr_clr && cfg_common),
        .wdata      (cfg_wdata[CMN_W-1:0]),
        .status     (cmn_status),
        .pending    (summary[NUM_CH])
    );

    assign irq = glb_irq_en && (summary != SUM_W'(0));

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_irq_en |-> !irq));
    // R7
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq |-> (summary != SUM_W'(0))));
    // R4
    summary_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch_status == '0 && cmn_status == '0) |-> (summary == SUM_W'(0))));
endmodule

// File: tb/dma_irq_aggr_tb_top.sv
module dma_irq_aggr_tb_top;
    localparam int NUM_CH = 8;
    localparam int CH_W   = 32;
    localparam int CMN_W  = 21;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [NUM_CH*CH_W-1:0] ch_evt = '0;
    logic [CMN_W-1:0]       cmn_evt = '0;
    logic                   cfg_we = 1'b0;
    logic [1:0]             cfg_kind = 2'd3;
    logic                   cfg_common = 1'b0;
    logic [2:0]             cfg_chan = '0;
    logic [31:0]            cfg_wdata = '0;
    logic                   glb_irq_en = 1'b0;
    logic [NUM_CH*CH_W-1:0] ch_status;
    logic [CMN_W-1:0]       cmn_status;
    logic [NUM_CH:0]        summary;
    logic                   irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    dma_irq_aggr dut_i (
        .clk(clk), .rst_n(rst_n), .ch_evt(ch_evt), .cmn_evt(cmn_evt),
        .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_common(cfg_common),
        .cfg_chan(cfg_chan), .cfg_wdata(cfg_wdata), .glb_irq_en(glb_irq_en),
        .ch_status(ch_status), .cmn_status(cmn_status), .summary(summary), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] chs(input int c);
        return ch_status[c*CH_W +: CH_W];
    endfunction

    task automatic wr(input logic [1:0] kind, input logic com, input int ch, input logic [31:0] d);
        cfg_we = 1'b1; cfg_kind = kind; cfg_common = com; cfg_chan = 3'(ch); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_kind = 2'd3;
    endtask

    task automatic pulse(input int ch, input logic [31:0] m);
        ch_evt[ch*CH_W +: CH_W] = m;
        @(negedge clk);
        ch_evt = '0;
    endtask

    task automatic t_reset;
        chk("R1 ch0 status", chs(0), 0);
        chk("R1 cmn status", 32'(cmn_status), 0);
        chk("R1 summary", 32'(summary), 0);
        chk("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_stat_gate;
        pulse(2, 32'h1);
        chk("R2 disabled event ignored", chs(2), 0);
        wr(2'd0, 1'b0, 2, 32'h8000_0001);
        pulse(2, 32'h1);
        chk("R2 R10 enabled event latched", chs(2), 32'h1);
        pulse(2, 32'h0000_0002);
        chk("R2 bit1 not enabled", chs(2), 32'h1);
    endtask

    task automatic t_sig_gate;
        glb_irq_en = 1'b1;
        @(negedge clk);
        chk("R3 recorded not signalled summary", 32'(summary), 0);
        chk("R3 irq low", 32'(irq), 0);
        wr(2'd1, 1'b0, 2, 32'h1);
        chk("R4 summary bit2", 32'(summary), 32'h4);
        chk("R7 irq high", 32'(irq), 1);
    endtask

    task automatic t_clear;
        pulse(2, 32'h8000_0000);
        chk("R2 bit31 latched", chs(2), 32'h8000_0001);
        wr(2'd2, 1'b0, 2, 32'h1);
        chk("R5 clear only masked bit", chs(2), 32'h8000_0000);
        chk("R4 summary drops", 32'(summary), 0);
        chk("R7 irq drops", 32'(irq), 0);
        wr(2'd2, 1'b0, 2, 32'h0);
        chk("R5 zero mask no effect", chs(2), 32'h8000_0000);
    endtask

    task automatic t_collision;
        ch_evt[2*CH_W +: CH_W] = 32'h1;
        cfg_we = 1'b1; cfg_kind = 2'd2; cfg_common = 1'b0; cfg_chan = 3'd2; cfg_wdata = 32'h8000_0001;
        @(negedge clk);
        ch_evt = '0; cfg_we = 1'b0; cfg_kind = 2'd3;
        chk("R6 event wins over clear", chs(2), 32'h1);
        chk("R7 irq with event", 32'(irq), 1);
    endtask

    task automatic t_global;
        glb_irq_en = 1'b0;
        @(negedge clk);
        chk("R7 global gate irq", 32'(irq), 0);
        chk("R7 summary kept", 32'(summary), 32'h4);
        glb_irq_en = 1'b1;
        @(negedge clk);
        chk("R7 irq back", 32'(irq), 1);
    endtask

    task automatic t_common;
        wr(2'd0, 1'b1, 0, 32'h0000_0101);
        wr(2'd1, 1'b1, 0, 32'h0000_0100);
        chk("R9 ch2 untouched by common writes", chs(2), 32'h1);
        cmn_evt = 21'h000181;
        @(negedge clk);
        cmn_evt = '0;
        chk("R8 common status", 32'(cmn_status), 32'h101);
        chk("R8 R4 common summary", 32'(summary), 32'h104);
        wr(2'd2, 1'b1, 0, 32'h100);
        chk("R8 common clear", 32'(cmn_status), 32'h1);
        chk("R4 common summary drops", 32'(summary), 32'h4);
    endtask

    task automatic t_isolation;
        wr(2'd0, 1'b0, 7, 32'hFFFF_FFFF);
        wr(2'd1, 1'b0, 7, 32'h0000_0008);
        pulse(7, 32'h0000_0008);
        pulse(3, 32'h0000_0008);
        chk("R9 ch3 unaffected", chs(3), 0);
        chk("R4 ch7 summary", 32'(summary), 32'h84);
        wr(2'd3, 1'b0, 7, 32'hFFFF_FFFF);
        chk("R9 kind3 ignored", chs(7), 32'h8);
        wr(2'd2, 1'b0, 3, 32'hFFFF_FFFF);
        chk("R9 clear other channel", chs(7), 32'h8);
        wr(2'd2, 1'b0, 7, 32'h8);
        wr(2'd2, 1'b0, 2, 32'h1);
        chk("R7 all cleared irq low", 32'(irq), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_stat_gate();
        t_sig_gate();
        t_clear();
        t_collision();
        t_global();
        t_common();
        t_isolation();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule